// File: doc/BRIEF.md
# Snoopy Write-Back Cache Line Coherence Controller

This block holds the ownership state of every line in one private write-back cache that sits on a shared snooping bus. The scheme has three states. A line is either invalid, a read-only shared copy, or a read-write copy that this cache alone owns. Each cycle the block takes at most one local processor event (read, write or replace) and at most one snooped remote bus transaction (read or write). It reports a hit, the bus request that the local event needs, any writeback forced by the snoop, and the next state of both addressed lines. State changes take effect at the next clock edge.

Any local write takes unique ownership. When the line is not already read-write, the write issues a read-for-ownership request, and that request invalidates remote copies. A remote write, or a local replacement, drops the line to invalid. A remote read of an owned line forces the dirty data out and leaves a shared copy. Lines are selected by a direct index. Arbitration, data storage and memory sit outside the block.

Top module: `snoopCoherCtl`

## Requirements
- R1: After reset every line is invalid. The state code on both next-state outputs is INV=0, RO=1, RW=2.
- R2: A local read (`locOp`=0) of an invalid line raises `reqRead`, leaves `locHit` low and makes the line RO.
- R3: A local read of an RO or RW line raises `locHit`, requests nothing and leaves the state unchanged.
- R4: A local write (`locOp`=1) to an INV or RO line raises `reqReadOwn` and makes the line RW. `locHit` is high only when the line was RO.
- R5: A local write to an RW line raises `locHit`, requests nothing and keeps RW.
- R6: A local replace (`locOp`=2) makes the line INV. It raises `reqWriteBack` only when the line was RW.
- R7: A snooped remote write (`snpWrite`=1) makes the addressed line INV from any state, with no writeback.
- R8: A snooped remote read (`snpWrite`=0) of an RW line raises `snpWriteBack` and makes the line RO. On an RO or INV line it changes nothing and requests nothing.
- R9: When the snoop and the local event address the same line in one cycle, the snoop acts first. The local event then acts on the state the snoop left, and the local result is the stored state. `snpNextState` shows the snoop result alone.
- R10: With `locValid` low, or with `locOp`=3, no local request or hit is raised and no state changes. `locNextState` then shows the current state of `locIdx`. The same holds for `snpNextState` when `snpValid` is low.
- R11: An event on one index leaves every other line unchanged.
- R12: At most one of `reqRead`, `reqReadOwn` and `reqWriteBack` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| locValid | input | 1 | Local event present |
| locOp | input | 2 | 0 read, 1 write, 2 replace, 3 reserved |
| locIdx | input | IDX_W | Line index of the local event |
| snpValid | input | 1 | Snooped transaction present |
| snpWrite | input | 1 | 1 remote write, 0 remote read |
| snpIdx | input | IDX_W | Line index of the snooped transaction |
| locHit | output | 1 | Local read or write found the line present |
| locNextState | output | 2 | State of `locIdx` after this cycle |
| reqRead | output | 1 | Bus read for a read miss |
| reqReadOwn | output | 1 | Bus read-for-ownership that invalidates others |
| reqWriteBack | output | 1 | Writeback caused by a local replace |
| snpNextState | output | 2 | State of `snpIdx` after the snoop |
| snpWriteBack | output | 1 | Writeback forced by a snooped read |

## Verification
A line stored in the wrong state shows up at the ports the next time that index is addressed. A probe cycle with no valid events reveals the state directly on the next-state outputs. A live event reveals it through a wrong hit or a wrong request. The sweep therefore checks both outputs in every cycle, and it probes the target line and a second line right after each event, so a corrupted or leaked update is caught within one cycle. Same-line collisions are driven for every snoop kind against every local operation and start state, which exposes wrong ordering.

// File: rtl/snoopPkg.sv
package snoopPkg;
  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_RO  = 2'd1,
    LINE_RW  = 2'd2
  } lineState_e;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_REPLACE = 2'd2,
    OP_NONE    = 2'd3
  } locOp_e;

  typedef struct packed {
    logic       snpWe;
    lineState_e snpNext;
    logic       locWe;
    lineState_e locNext;
    logic       hit;
    logic       busRead;
    logic       busReadOwn;
    logic       busWriteBack;
    logic       snpFlush;
  } strobe_t;
endpackage

// File: rtl/snoopLineStore.sv
module snoopLineStore
  import snoopPkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] locIdx,
  input  logic [IDX_W-1:0] snpIdx,
  input  strobe_t          stb,
  output lineState_e       locState,
  output lineState_e       snpState
);
  lineState_e lines [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lines[i] <= LINE_INV;
      end else if (stb.locWe && (locIdx == IDX_W'(i))) begin
        lines[i] <= stb.locNext;
      end else if (stb.snpWe && (snpIdx == IDX_W'(i))) begin
        lines[i] <= stb.snpNext;
      end
    end
  end

  assign locState = lines[locIdx];
  assign snpState = lines[snpIdx];
endmodule

// File: rtl/snoopLineCtrl.sv
module snoopLineCtrl
  import snoopPkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             locValid,
  input  logic [1:0]       locOp,
  input  logic [IDX_W-1:0] locIdx,
  input  logic             snpValid,
  input  logic             snpWrite,
  input  logic [IDX_W-1:0] snpIdx,
  input  lineState_e       locState,
  input  lineState_e       snpState,
  output strobe_t          stb
);
  lineState_e snpEff;
  lineState_e baseState;
  lineState_e locEff;
  locOp_e     opKind;

  assign opKind = locOp_e'(locOp);

  always_comb begin
    snpEff = snpState;
    if (snpValid) begin
      if (snpWrite) begin
        snpEff = LINE_INV;
      end else if (snpState == LINE_RW) begin
        snpEff = LINE_RO;
      end
    end
  end

  assign baseState = (snpValid && (snpIdx == locIdx)) ? snpEff : locState;

  always_comb begin
    stb          = '0;
    stb.snpWe    = snpValid;
    stb.snpNext  = snpEff;
    stb.snpFlush = snpValid && !snpWrite && (snpState == LINE_RW);
    locEff       = baseState;
    if (locValid) begin
      unique case (opKind)
        OP_READ: begin
          if (baseState == LINE_INV) begin
            stb.busRead = 1'b1;
            locEff      = LINE_RO;
          end else begin
            stb.hit = 1'b1;
          end
        end
        OP_WRITE: begin
          stb.hit        = (baseState != LINE_INV);
          stb.busReadOwn = (baseState != LINE_RW);
          locEff         = LINE_RW;
        end
        OP_REPLACE: begin
          stb.busWriteBack = (baseState == LINE_RW);
          locEff           = LINE_INV;
        end
        OP_NONE: begin
          locEff = baseState;
        end
      endcase
    end
    stb.locWe   = locValid && (opKind != OP_NONE);
    stb.locNext = locEff;
  end
endmodule

// File: rtl/snoopCoherCtl.sv
module snoopCoherCtl
  import snoopPkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             locValid,
  input  logic [1:0]       locOp,
  input  logic [IDX_W-1:0] locIdx,
  input  logic             snpValid,
  input  logic             snpWrite,
  input  logic [IDX_W-1:0] snpIdx,
  output logic             locHit,
  output logic [1:0]       locNextState,
  output logic             reqRead,
  output logic             reqReadOwn,
  output logic             reqWriteBack,
  output logic [1:0]       snpNextState,
  output logic             snpWriteBack
);
  strobe_t    stb;
  lineState_e locState;
  lineState_e snpState;

  snoopLineStore #(.NUM_LINES(NUM_LINES)) uStore (
    .clk      (clk),
    .rstN     (rstN),
    .locIdx   (locIdx),
    .snpIdx   (snpIdx),
    .stb      (stb),
    .locState (locState),
    .snpState (snpState)
  );

  snoopLineCtrl #(.NUM_LINES(NUM_LINES)) uCtrl (
    .locValid (locValid),
    .locOp    (locOp),
    .locIdx   (locIdx),
    .snpValid (snpValid),
    .snpWrite (snpWrite),
    .snpIdx   (snpIdx),
    .locState (locState),
    .snpState (snpState),
    .stb      (stb)
  );

  assign locHit       = stb.hit;
  assign locNextState = stb.locNext;
  assign reqRead      = stb.busRead;
  assign reqReadOwn   = stb.busReadOwn;
  assign reqWriteBack = stb.busWriteBack;
  assign snpNextState = stb.snpNext;
  assign snpWriteBack = stb.snpFlush;
endmodule

// File: rtl/snoopCoherChk.sv
module snoopCoherChk #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             locValid,
  input logic [1:0]       locOp,
  input logic [IDX_W-1:0] locIdx,
  input logic             snpValid,
  input logic             snpWrite,
  input logic [IDX_W-1:0] snpIdx,
  input logic             locHit,
  input logic [1:0]       locNextState,
  input logic             reqRead,
  input logic             reqReadOwn,
  input logic             reqWriteBack,
  input logic [1:0]       snpNextState,
  input logic             snpWriteBack
);
  a_r2_miss_fills_shared: assert property (@(posedge clk) disable iff (!rstN)
    (locValid && locOp == 2'd0 && !locHit) |-> (reqRead && locNextState == 2'd1));

  a_r4_own_request_takes_rw: assert property (@(posedge clk) disable iff (!rstN)
    reqReadOwn |-> (locValid && locOp == 2'd1 && locNextState == 2'd2));

  a_r5_written_line_hits: assert property (@(posedge clk) disable iff (!rstN)
    (locValid && locOp == 2'd1) |=>
      (!(locValid && locOp == 2'd0 && locIdx == $past(locIdx) &&
         !(snpValid && snpIdx == locIdx)) || (locHit && !reqRead)));

  a_r6_writeback_on_replace: assert property (@(posedge clk) disable iff (!rstN)
    reqWriteBack |-> (locValid && locOp == 2'd2 && locNextState == 2'd0));

  a_r7_remote_write_kills: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpWrite) |-> (snpNextState == 2'd0 && !snpWriteBack));

  a_r8_flush_downgrades: assert property (@(posedge clk) disable iff (!rstN)
    snpWriteBack |-> (snpValid && !snpWrite && snpNextState == 2'd1));

  a_r10_idle_requests_nothing: assert property (@(posedge clk) disable iff (!rstN)
    (!locValid || locOp == 2'd3) |-> !(reqRead || reqReadOwn || reqWriteBack || locHit));

  a_r12_single_request: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqRead, reqReadOwn, reqWriteBack}));
endmodule

bind snoopCoherCtl snoopCoherChk #(.NUM_LINES(NUM_LINES)) uChk (.*);

// File: tb/tb_snoopCoherCtl.sv
module tb_snoopCoherCtl;
  localparam int NL = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          locValid = 1'b0;
  logic [1:0]    locOp = 2'd3;
  logic [IW-1:0] locIdx = '0;
  logic          snpValid = 1'b0;
  logic          snpWrite = 1'b0;
  logic [IW-1:0] snpIdx = '0;
  logic          locHit, reqRead, reqReadOwn, reqWriteBack, snpWriteBack;
  logic [1:0]    locNextState, snpNextState;

  int mdl [NL];
  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  snoopCoherCtl #(.NUM_LINES(NL)) dut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare before posedge, advance the model.
  task automatic apply(input bit lv, input int lop, input int li,
                       input bit sv, input bit sw, input int si);
    int sEff, base, lEff;
    bit eHit, eRd, eOwn, eWb, eSwb;
    string lTag, sTag;
    @(negedge clk);
    locValid = lv; locOp = 2'(lop); locIdx = IW'(li);
    snpValid = sv; snpWrite = sw; snpIdx = IW'(si);
    #1;
    sEff = mdl[si];
    if (sv) sEff = sw ? 0 : ((mdl[si] == 2) ? 1 : mdl[si]);
    eSwb = sv && !sw && (mdl[si] == 2);
    base = (sv && si == li) ? sEff : mdl[li];
    lEff = base; eHit = 0; eRd = 0; eOwn = 0; eWb = 0;
    lTag = "R10";
    if (lv && lop == 0) begin
      if (base == 0) begin eRd = 1; lEff = 1; lTag = "R2"; end
      else begin eHit = 1; lTag = "R3"; end
    end else if (lv && lop == 1) begin
      eHit = (base != 0); eOwn = (base != 2); lEff = 2;
      lTag = (base == 2) ? "R5" : "R4";
    end else if (lv && lop == 2) begin
      eWb = (base == 2); lEff = 0; lTag = "R6";
    end
    if (sv && si == li && lv && lop != 3) lTag = "R9";
    sTag = !sv ? "R10" : (sw ? "R7" : "R8");
    chk(lTag, "locHit", int'(locHit), int'(eHit));
    chk(lTag, "reqRead", int'(reqRead), int'(eRd));
    chk(lTag, "reqReadOwn", int'(reqReadOwn), int'(eOwn));
    chk(lTag, "reqWriteBack", int'(reqWriteBack), int'(eWb));
    chk(lTag, "locNextState", int'(locNextState), lEff);
    chk(sTag, "snpWriteBack", int'(snpWriteBack), int'(eSwb));
    chk(sTag, "snpNextState", int'(snpNextState), sEff);
    chk("R12", "requestCount", int'(reqRead) + int'(reqReadOwn) + int'(reqWriteBack) > 1 ? 1 : 0, 0);
    if (sv) mdl[si] = sEff;
    if (lv && lop != 3) mdl[li] = lEff;
  endtask

  // Idle probe: both next-state outputs show stored state (R11 for the untouched line).
  task automatic probe(input int a, input int b, input string tag);
    @(negedge clk);
    locValid = 0; locOp = 2'd0; locIdx = IW'(a);
    snpValid = 0; snpWrite = 0; snpIdx = IW'(b);
    #1;
    chk(tag, "probeLocState", int'(locNextState), mdl[a]);
    chk("R11", "probeOtherState", int'(snpNextState), mdl[b]);
  endtask

  task automatic setLine(input int li, input int st);
    apply(1, 2, li, 0, 0, li);
    if (st >= 1) apply(1, 0, li, 0, 0, li);
    if (st == 2) apply(1, 1, li, 0, 0, li);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < NL; i++) begin
      @(negedge clk);
      locValid = 0; locIdx = IW'(i); snpValid = 0; snpIdx = IW'((i + 1) % NL);
      #1;
      chk("R1", "resetLocState", int'(locNextState), 0);
      chk("R1", "resetSnpState", int'(snpNextState), 0);
    end
    for (int idx = 0; idx < NL; idx++)
      for (int st = 0; st < 3; st++)
        for (int lop = 0; lop < 5; lop++)
          for (int sk = 0; sk < 3; sk++)
            for (int same = 0; same < 2; same++) begin
              int oi;
              oi = (idx + 3) % NL;
              setLine(idx, st);
              setLine(oi, (st + 1) % 3);
              // lop 4: local write presented with locValid low
              apply(lop != 4, (lop == 4) ? 1 : lop, idx,
                    sk != 0, sk == 2, same ? idx : oi);
              probe(idx, oi, (lop >= 3) ? "R10" : "R9");
              probe(oi, (idx + 5) % NL, "R11");
            end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule